// File: doc/BRIEF.md
# NAND Command/Address Sequencer

This block turns one host request into the command and address cycles of a raw 8-bit NAND device bus, then handles the device's busy period. A request carries an opcode, an optional column address, an optional 20-bit page address, a flag for a 16-bit device bus and a flag for a third row-address byte. The block drives the command-latch and address-latch strobes, an active-low chip enable, an active-low write strobe and the output byte. After the address phase it applies a settle time. Depending on the opcode, it then finishes at once, waits for ready with a time limit, or waits for ready with no limit.

Program-setup requests get a read-pointer opcode in front of them. The pointer is chosen from the column, and the column is rebased to match. Read requests that carry a page address keep chip enable forced low through the busy period, so that the device sees an uninterrupted select. The host pulses `start` while `busy` is low, and it receives a one-cycle `done`, with `timeout` alongside if a bounded wait ran out. All delays are clock-cycle counts derived from a clock-frequency parameter.

Top module: `nand_cmd_seq`

## Requirements
- R1: Every request begins with command-latch cycles (`cle`=1, `ale`=0) carrying the opcode. For program setup (0x80), one pointer opcode comes before it within the same command phase.
- R2: Pointer choice for 0x80 with a column: column ≥ PAGE_BYTES gives 0x50 and the column reduced by PAGE_BYTES. Column < 256 gives 0x00 and the column unchanged. Any other column gives 0x01 and the column reduced by 256. Without a column the pointer is 0x00.
- R3: Address cycles (`ale`=1) are sent only when a column or a page is supplied, in this order: column byte, page[7:0], page[15:8], then `{4'b0, page[19:16]}` only when `row3` is set.
- R4: On a 16-bit bus (`wide_bus`=1), the column (after R2 rebasing) is halved before its low 8 bits are sent. The 8-bit-only opcodes 0x90, 0xEC, 0xEE and 0xEF are never halved.
- R5: Each bus byte holds `nwe` low for WE_LOW cycles and then high for WE_HIGH cycles, with `dq` constant across both. `cle` and `ale` are never high together.
- R6: When an address phase took place, a settle time of SETTLE_CYC cycles follows it.
- R7: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 finish right after the bus and settle phases, with no ready wait.
- R8: Reads (0x00, 0x01, 0x50) that carry a page wait TWB_CYC cycles, then poll `dev_rdy` for at most READ_STEPS×STEP_CYC cycles. Running out of that budget gives `done` with `timeout`=1.
- R9: All other requests, including reads without a page, wait TWB_CYC cycles and then poll `dev_rdy` with no limit. They never assert `timeout`.
- R10: For reads with a page, `nce` stays low from the address phase until the wait ends. For all other requests, `nce` is high whenever no bus byte is in progress.
- R11: `done` is a one-cycle pulse, one cycle after the completing condition. `busy` falls with it.
- R12: A `start` while `busy` is high is ignored and does not alter the request in progress.
- R13: During and after reset: `busy`=0, `done`=0, `nce`=1, `nwe`=1, `cle`=0, `ale`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| opcode | input | 8 | Command opcode |
| col_valid | input | 1 | A column address is supplied |
| col_addr | input | COL_W | Column address |
| page_valid | input | 1 | A page address is supplied |
| page_addr | input | 20 | Page (row) address |
| wide_bus | input | 1 | Device uses a 16-bit bus |
| row3 | input | 1 | Send a third row-address byte |
| dev_rdy | input | 1 | Controller status bit 0, 1 = device ready |
| cle | output | 1 | Command-latch enable |
| ale | output | 1 | Address-latch enable |
| nce | output | 1 | Chip enable, active low |
| nwe | output | 1 | Write strobe, active low |
| dq | output | 8 | Bus byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Bounded wait ran out, valid with done |

## Verification
Counting from the edge that takes `start`, the design is in its first write-low cycle at the following sample. The N bytes occupy N×(WE_LOW+WE_HIGH) cycles, settle adds SETTLE_CYC when addresses were sent, and waiting requests add TWB_CYC plus at least one polling cycle. `done` is visible one cycle after the last of these. If ready is raised at a sample inside the wait, `done` appears at the next sample. The bench samples every output on the falling edge. It counts samples from the start edge and compares the sample where `done` first appears with that sum, computed independently for each request. It rebuilds the byte stream arithmetically for every column value over a full page and its spare area.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/100ps
package nand_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WLOW,
        ST_WHIGH,
        ST_SETTLE,
        ST_TWB,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        WAIT_NONE,
        WAIT_BOUNDED,
        WAIT_FOREVER
    } wait_kind_e;

    // row address: two full bytes plus one nibble
    localparam int ROW_W     = 20;
    localparam int ROW_BYTES = 3;

    // byte slots in bus order
    localparam int SLOT_PTR  = 0;
    localparam int SLOT_CMD  = 1;
    localparam int SLOT_COL  = 2;
    localparam int SLOT_ROW0 = 3;
    localparam int NSLOT     = SLOT_ROW0 + ROW_BYTES;
    localparam int IDX_W     = $clog2(NSLOT);

    localparam logic [7:0] OP_RD_LO      = 8'h00;
    localparam logic [7:0] OP_RD_HI      = 8'h01;
    localparam logic [7:0] OP_RD_SPARE   = 8'h50;
    localparam logic [7:0] OP_PROG_SETUP = 8'h80;
    localparam logic [7:0] OP_PROG_GO    = 8'h10;
    localparam logic [7:0] OP_ERASE_SET  = 8'h60;
    localparam logic [7:0] OP_ERASE_GO   = 8'hD0;
    localparam logic [7:0] OP_STATUS     = 8'h70;

endpackage

// File: rtl/nand_ptr_select.sv
`timescale 1ns/100ps
module nand_ptr_select
    import nand_seq_pkg::*;
#(
    parameter int COL_W      = 12,
    parameter int PAGE_BYTES = 512
) (
    input  logic [7:0]       opcode,
    input  logic             col_v,
    input  logic [COL_W-1:0] col,
    input  logic             wide,
    output logic [7:0]       ptr_op,
    output logic [7:0]       col_byte
);
    localparam logic [COL_W-1:0] PG_SIZE = COL_W'(PAGE_BYTES);
    localparam logic [COL_W-1:0] HALF_PG = COL_W'(256);

    logic [COL_W-1:0] rebased;
    logic [COL_W-1:0] scaled;
    logic             byte_only_op;

    always_comb begin
        rebased = col;
        ptr_op  = OP_RD_LO;
        if (opcode == OP_PROG_SETUP && col_v) begin
            if (col >= PG_SIZE) begin
                ptr_op  = OP_RD_SPARE;
                rebased = col - PG_SIZE;
            end else if (col >= HALF_PG) begin
                ptr_op  = OP_RD_HI;
                rebased = col - HALF_PG;
            end
        end
        byte_only_op = (opcode == 8'h90) || (opcode == 8'hEC) ||
                       (opcode == 8'hEE) || (opcode == 8'hEF);
        scaled   = (wide && !byte_only_op) ? (rebased >> 1) : rebased;
        col_byte = 8'(scaled);
    end
endmodule

// File: rtl/nand_cmd_class.sv
`timescale 1ns/100ps
module nand_cmd_class
    import nand_seq_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       page_v,
    output wait_kind_e kind,
    output logic       hold_ce
);
    logic is_read;
    logic no_wait;

    always_comb begin
        is_read = (opcode == OP_RD_LO) || (opcode == OP_RD_HI) ||
                  (opcode == OP_RD_SPARE);
        no_wait = (opcode == OP_PROG_GO) || (opcode == OP_ERASE_SET) ||
                  (opcode == OP_ERASE_GO) || (opcode == OP_PROG_SETUP) ||
                  (opcode == OP_STATUS);
        hold_ce = is_read && page_v;
        if (no_wait)      kind = WAIT_NONE;
        else if (hold_ce) kind = WAIT_BOUNDED;
        else              kind = WAIT_FOREVER;
    end
endmodule

// File: rtl/nand_slot_plan.sv
`timescale 1ns/100ps
module nand_slot_plan
    import nand_seq_pkg::*;
(
    input  logic                      prog_setup,
    input  logic [7:0]                ptr_op,
    input  logic [7:0]                opcode,
    input  logic                      col_v,
    input  logic [7:0]                col_byte,
    input  logic                      page_v,
    input  logic [ROW_W-1:0]          page,
    input  logic                      row3,
    output logic [NSLOT-1:0]          vld,
    output logic [NSLOT-1:0][7:0]     bytes,
    output logic [NSLOT-1:0]          is_addr
);
    assign vld[SLOT_PTR]     = prog_setup;
    assign bytes[SLOT_PTR]   = ptr_op;
    assign is_addr[SLOT_PTR] = 1'b0;

    assign vld[SLOT_CMD]     = 1'b1;
    assign bytes[SLOT_CMD]   = opcode;
    assign is_addr[SLOT_CMD] = 1'b0;

    assign vld[SLOT_COL]     = col_v;
    assign bytes[SLOT_COL]   = col_byte;
    assign is_addr[SLOT_COL] = 1'b1;

    for (genvar k = 0; k < ROW_BYTES; k++) begin : g_row
        assign is_addr[SLOT_ROW0+k] = 1'b1;
        if (k < ROW_BYTES - 1) begin : g_full
            assign vld[SLOT_ROW0+k]   = page_v;
            assign bytes[SLOT_ROW0+k] = page[8*k +: 8];
        end else begin : g_nib
            assign vld[SLOT_ROW0+k]   = page_v && row3;
            assign bytes[SLOT_ROW0+k] = {4'b0000, page[8*k +: 4]};
        end
    end
endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/100ps
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int CLK_MHZ    = 200,
    parameter int PAGE_BYTES = 512,
    parameter int COL_W      = 12,
    parameter int WE_LOW     = 2,
    parameter int WE_HIGH    = 2,
    parameter int SETTLE_NS  = 1000,
    parameter int TWB_NS     = 100,
    parameter int STEP_NS    = 1000,
    parameter int READ_STEPS = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic             col_valid,
    input  logic [COL_W-1:0] col_addr,
    input  logic             page_valid,
    input  logic [ROW_W-1:0] page_addr,
    input  logic             wide_bus,
    input  logic             row3,
    input  logic             dev_rdy,
    output logic             cle,
    output logic             ale,
    output logic             nce,
    output logic             nwe,
    output logic [7:0]       dq,
    output logic             busy,
    output logic             done,
    output logic             timeout
);
    function automatic int ns_to_cyc(int ns);
        int c;
        c = (CLK_MHZ * ns + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS);
    localparam int TWB_CYC    = ns_to_cyc(TWB_NS);
    localparam int STEP_CYC   = ns_to_cyc(STEP_NS);
    localparam int WAIT_LIMIT = READ_STEPS * STEP_CYC;
    localparam int MAX_CNT    = max2(max2(max2(WE_LOW, WE_HIGH), max2(SETTLE_CYC, TWB_CYC)), WAIT_LIMIT);
    localparam int CNT_W      = $clog2(MAX_CNT + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             force_ce;
        logic             tmo;
        logic [7:0]       op;
        logic             col_v;
        logic [COL_W-1:0] col;
        logic             page_v;
        logic [ROW_W-1:0] page;
        logic             wide;
        logic             row3;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [7:0]            ptr_op;
    logic [7:0]            col_byte;
    wait_kind_e            kind;
    logic                  hold_ce;
    logic [NSLOT-1:0]      slot_vld;
    logic [NSLOT-1:0][7:0] slot_byte;
    logic [NSLOT-1:0]      slot_addr;

    nand_ptr_select #(.COL_W(COL_W), .PAGE_BYTES(PAGE_BYTES)) i_ptr (
        .opcode   (q.op),
        .col_v    (q.col_v),
        .col      (q.col),
        .wide     (q.wide),
        .ptr_op   (ptr_op),
        .col_byte (col_byte)
    );

    nand_cmd_class i_class (
        .opcode  (q.op),
        .page_v  (q.page_v),
        .kind    (kind),
        .hold_ce (hold_ce)
    );

    nand_slot_plan i_plan (
        .prog_setup (q.op == OP_PROG_SETUP),
        .ptr_op     (ptr_op),
        .opcode     (q.op),
        .col_v      (q.col_v),
        .col_byte   (col_byte),
        .page_v     (q.page_v),
        .page       (q.page),
        .row3       (q.row3),
        .vld        (slot_vld),
        .bytes      (slot_byte),
        .is_addr    (slot_addr)
    );

    logic             nxt_found;
    logic [IDX_W-1:0] nxt_idx;
    logic             any_addr;
    logic             on_bus;

    always_comb begin
        nxt_found = 1'b0;
        nxt_idx   = q.idx;
        for (int j = 0; j < NSLOT; j++) begin
            if (!nxt_found && (j > int'(q.idx)) && slot_vld[j]) begin
                nxt_found = 1'b1;
                nxt_idx   = IDX_W'(j);
            end
        end
        any_addr = q.col_v || q.page_v;
    end

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_WLOW;
                    d.idx      = (opcode == OP_PROG_SETUP) ? IDX_W'(SLOT_PTR) : IDX_W'(SLOT_CMD);
                    d.cnt      = '0;
                    d.force_ce = 1'b0;
                    d.tmo      = 1'b0;
                    d.op       = opcode;
                    d.col_v    = col_valid;
                    d.col      = col_addr;
                    d.page_v   = page_valid;
                    d.page     = page_addr;
                    d.wide     = wide_bus;
                    d.row3     = row3;
                end
            end
            ST_WLOW: begin
                if (q.cnt == CNT_W'(WE_LOW - 1)) begin
                    d.st  = ST_WHIGH;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WHIGH: begin
                if (q.cnt == CNT_W'(WE_HIGH - 1)) begin
                    d.cnt = '0;
                    if (q.idx == IDX_W'(SLOT_ROW0) && hold_ce)
                        d.force_ce = 1'b1;
                    if (nxt_found) begin
                        d.idx = nxt_idx;
                        d.st  = ST_WLOW;
                    end else if (any_addr) begin
                        d.st = ST_SETTLE;
                    end else if (kind == WAIT_NONE) begin
                        d.st = ST_DONE;
                    end else begin
                        d.st = ST_TWB;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (q.cnt == CNT_W'(SETTLE_CYC - 1)) begin
                    d.cnt = '0;
                    d.st  = (kind == WAIT_NONE) ? ST_DONE : ST_TWB;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_TWB: begin
                if (q.cnt == CNT_W'(TWB_CYC - 1)) begin
                    d.cnt = '0;
                    d.st  = ST_WAIT;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (dev_rdy) begin
                    d.st       = ST_DONE;
                    d.force_ce = 1'b0;
                end else if (kind == WAIT_BOUNDED) begin
                    if (q.cnt == CNT_W'(WAIT_LIMIT - 1)) begin
                        d.st       = ST_DONE;
                        d.tmo      = 1'b1;
                        d.force_ce = 1'b0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                d.st  = ST_IDLE;
                d.cnt = '0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        on_bus  = (q.st == ST_WLOW) || (q.st == ST_WHIGH);
        cle     = on_bus && !slot_addr[q.idx];
        ale     = on_bus && slot_addr[q.idx];
        dq      = on_bus ? slot_byte[q.idx] : 8'h00;
        nwe     = (q.st != ST_WLOW);
        nce     = !(on_bus || q.force_ce);
        busy    = (q.st != ST_IDLE);
        done    = (q.st == ST_DONE);
        timeout = done && q.tmo;
    end
endmodule

// File: rtl/nand_seq_checker.sv
`timescale 1ns/100ps
module nand_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cle,
    input logic       ale,
    input logic       nce,
    input logic       nwe,
    input logic [7:0] dq,
    input logic       busy,
    input logic       done,
    input logic       timeout
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale)); // R5
    AST_DQ_HELD:     assert property (@(posedge clk) disable iff (!rst_n) $rose(nwe) |-> $stable(dq)); // R5
    AST_CE_ON_BUS:   assert property (@(posedge clk) disable iff (!rst_n) (cle || ale) |-> !nce); // R10
    AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
    AST_TMO_DONE:    assert property (@(posedge clk) disable iff (!rst_n) timeout |-> done); // R8
    AST_BUSY_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R12
    AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (nce && nwe && !cle && !ale)); // R13
endmodule

bind nand_cmd_seq nand_seq_checker i_chk (.*);

// File: tb/test_nand_cmd_seq.sv
`timescale 1ns/100ps
module test_nand_cmd_seq;
    localparam int CLK_MHZ = 10;
    localparam int PGB     = 512;
    localparam int COL_W   = 12;
    localparam int WL      = 2;
    localparam int WH      = 1;
    localparam int STEPS   = 30;
    localparam int B       = WL + WH;
    localparam int S       = 10;
    localparam int T       = 1;
    localparam int LIMIT   = STEPS * 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic col_valid = 1'b0;
    logic [COL_W-1:0] col_addr = '0;
    logic page_valid = 1'b0;
    logic [19:0] page_addr = '0;
    logic wide_bus = 1'b0;
    logic row3 = 1'b0;
    logic dev_rdy = 1'b0;
    logic cle, ale, nce, nwe, busy, done, timeout;
    logic [7:0] dq;

    always #2.5 clk = ~clk;

    nand_cmd_seq #(
        .CLK_MHZ(CLK_MHZ), .PAGE_BYTES(PGB), .COL_W(COL_W),
        .WE_LOW(WL), .WE_HIGH(WH), .READ_STEPS(STEPS)
    ) i_nand_cmd_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .col_valid(col_valid), .col_addr(col_addr), .page_valid(page_valid),
        .page_addr(page_addr), .wide_bus(wide_bus), .row3(row3),
        .dev_rdy(dev_rdy), .cle(cle), .ale(ale), .nce(nce), .nwe(nwe),
        .dq(dq), .busy(busy), .done(done), .timeout(timeout)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int    exp_n;
    int    exp_b [8];
    bit    exp_a [8];
    string exp_r [8];
    int    got_n;
    int    got_b [8];
    bit    got_a [8];
    bit    got_c [8];

    task automatic push(int v, bit a, string r);
        exp_b[exp_n] = v;
        exp_a[exp_n] = a;
        exp_r[exp_n] = r;
        exp_n++;
    endtask

    task automatic plan(logic [7:0] op, bit cv, int col, bit pv, int page, bit w, bit r3);
        int c;
        int p;
        c = col;
        exp_n = 0;
        if (op == 8'h80) begin
            if (!cv)            p = 8'h00;
            else if (c >= PGB)  begin p = 8'h50; c = c - PGB; end
            else if (c < 256)   p = 8'h00;
            else                begin p = 8'h01; c = c - 256; end
            push(p, 1'b0, "R2");
        end
        push(op, 1'b0, "R1");
        if (cv) begin
            if (w && !(op inside {8'h90, 8'hEC, 8'hEE, 8'hEF})) c = c >> 1;
            push(c & 255, 1'b1, "R4");
        end
        if (pv) begin
            push(page & 255, 1'b1, "R3");
            push((page >> 8) & 255, 1'b1, "R3");
            if (r3) push((page >> 16) & 15, 1'b1, "R3");
        end
    endtask

    // rdy_mode: 0 ready throughout, >0 raise that many samples into the wait, <0 never
    task automatic run(logic [7:0] op, bit cv, int col, bit pv, int page, bit w, bit r3,
                       int rdy_mode, bit glitch);
        int kind, pre, exp_done, raise_k, done_k, k, low_cnt, bus_cnt, ce_free, got_t;
        bit exp_tmo, prev_nwe, addr;
        string lreq;
        plan(op, cv, col, pv, page, w, r3);
        addr = cv || pv;
        if (op inside {8'h10, 8'h60, 8'hD0, 8'h80, 8'h70}) kind = 0;
        else if ((op inside {8'h00, 8'h01, 8'h50}) && pv) kind = 1;
        else kind = 2;
        pre = exp_n * B + (addr ? S : 0);
        raise_k = -1;
        if (kind == 0)          exp_done = pre + 1;
        else if (rdy_mode == 0) exp_done = pre + T + 2;
        else if (rdy_mode > 0)  begin raise_k = pre + T + rdy_mode; exp_done = raise_k + 1; end
        else if (kind == 1)     exp_done = pre + T + LIMIT + 1;
        else                    begin raise_k = pre + T + LIMIT + 20; exp_done = raise_k + 1; end
        exp_tmo = (kind == 1) && (rdy_mode < 0);
        lreq = (kind == 0) ? ((addr) ? "R6" : "R7") : ((kind == 1) ? "R8" : "R9");

        @(negedge clk);
        opcode = op; col_valid = cv; col_addr = COL_W'(col); page_valid = pv;
        page_addr = 20'(page); wide_bus = w; row3 = r3;
        dev_rdy = (rdy_mode == 0); start = 1'b1;
        k = 0; got_n = 0; low_cnt = 0; bus_cnt = 0; ce_free = 0;
        done_k = -1; got_t = 0; prev_nwe = 1'b1;
        while (done_k < 0 && k < exp_done + 5) begin
            @(negedge clk);
            k++;
            if (!nwe && prev_nwe && got_n < 8) begin
                got_b[got_n] = dq; got_a[got_n] = ale; got_c[got_n] = cle; got_n++;
            end
            if (!nwe) low_cnt++;
            if (cle || ale) bus_cnt++;
            if (busy && !done && !cle && !ale && nce) ce_free++;
            if (done) begin done_k = k; got_t = timeout; end
            prev_nwe = nwe;
            start = glitch && (k == 3);
            if (glitch && k == 3) opcode = 8'h60;
            if (k == raise_k) begin
                if (kind == 2 && rdy_mode < 0)
                    check(done_k < 0, "R9", "done before ready", done_k, -1);
                dev_rdy = 1'b1;
            end
        end
        check(got_n == exp_n, "R1", "byte count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_b[i] == exp_b[i], exp_r[i], $sformatf("byte %0d value", i), got_b[i], exp_b[i]);
            check(got_a[i] == exp_a[i] && got_c[i] == !exp_a[i], exp_r[i],
                  $sformatf("byte %0d ale", i), got_a[i], exp_a[i]);
        end
        check(low_cnt == exp_n * WL, "R5", "write-low cycles", low_cnt, exp_n * WL);
        check(bus_cnt == exp_n * B, "R5", "bus cycles", bus_cnt, exp_n * B);
        check(done_k == exp_done, lreq, "done sample", done_k, exp_done);
        check(got_t == exp_tmo, (kind == 1) ? "R8" : "R9", "timeout", got_t, exp_tmo);
        if (kind == 1)
            check(ce_free == 0, "R10", "nce high during held read", ce_free, 0);
        else
            check(ce_free == exp_done - 1 - exp_n * B, "R10", "nce high after bus",
                  ce_free, exp_done - 1 - exp_n * B);
        start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!busy && !done, glitch ? "R12" : "R11", "idle after done", busy + 2 * done, 0);
        end
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] ops [11];
        ops = '{8'h00, 8'h01, 8'h50, 8'h10, 8'h60, 8'hD0, 8'h70, 8'hFF, 8'h90, 8'hEC, 8'h85};
        repeat (3) @(negedge clk);
        // R13: reset state
        check(!busy && !done && nce && nwe && !cle && !ale, "R13", "outputs in reset",
              {busy, done, nce, nwe, cle, ale}, 6'b001100);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && nce && nwe && !cle && !ale, "R13", "outputs after reset",
              {busy, done, nce, nwe, cle, ale}, 6'b001100);

        // R2 R4: program setup over every column of page plus spare area
        for (int wv = 0; wv < 2; wv++)
            for (int c = 0; c < PGB + 16; c++)
                run(8'h80, 1'b1, c, 1'b1, (c * 7919) & 20'hFFFFF, wv[0], c[0], 0, 1'b0);

        // R1 R3 R7 R9: opcode and address-presence sweep, ready already high
        foreach (ops[i])
            for (int m = 0; m < 4; m++)
                run(ops[i], m[0], 12'h1A5 + i, m[1], 20'hA5C3E + i * 77, m[0], i[0], 0, 1'b0);

        // R4: byte-only opcode keeps column on wide bus, read halves it
        run(8'h90, 1'b1, 12'h1A5, 1'b0, 0, 1'b1, 1'b0, 0, 1'b0);
        run(8'h00, 1'b1, 12'h1A5, 1'b0, 0, 1'b1, 1'b0, 0, 1'b0);
        run(8'h80, 1'b0, 0, 1'b1, 20'h12345, 1'b0, 1'b1, 0, 1'b0);

        // R8: bounded read wait, expiry and late ready
        run(8'h00, 1'b1, 3, 1'b1, 20'hF1234, 1'b0, 1'b1, -1, 1'b0);
        run(8'h50, 1'b0, 0, 1'b1, 20'h00777, 1'b0, 1'b0, 40, 1'b0);
        run(8'h01, 1'b1, 9, 1'b1, 20'h0BEEF, 1'b1, 1'b0, LIMIT, 1'b0);

        // R9: unbounded waits
        run(8'hFF, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0, -1, 1'b0);
        run(8'h00, 1'b1, 7, 1'b0, 0, 1'b0, 1'b0, -1, 1'b0);

        // R12: start while busy
        run(8'h70, 1'b0, 0, 1'b1, 20'h54321, 1'b0, 1'b1, 0, 1'b1);
        run(8'h00, 1'b1, 5, 1'b1, 20'h00abc, 1'b0, 1'b0, 25, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule